// File: doc/BRIEF.md
# Interleaved Display and Processor SRAM Arbiter

This block shares a single external SRAM port between a display scan-out reader and three processors. The block runs on the memory clock. It derives the pixel phase internally as a toggle at half that rate, so each pixel period holds two memory slots. The first slot of each pair is the display slot: the display reader always owns it, and the address comes straight from the scan-out address generator. The second slot is the processor slot, and it is shared among the processors through a fixed-priority request/acknowledge handshake.

A processor sets up its address, direction, width and write data, then raises its request. It waits for its acknowledge, takes its read word, and drops the request to end the transaction. The block performs exactly one memory access per grant. The owner keeps its grant until it releases the request, and only then is the next processor chosen. The returned display byte and the processor read words are registered inside the block. Reset overrides everything: no grant is given, nothing is written, and the data bus is left undriven.

Top module: `vga_cpu_sram_arb`

## Requirements
- R1: The slots alternate on every memory clock. While reset is held and in the first cycle after it is released, the display slot is current, which is shown by `pix_hi` = 1. In the processor slot `pix_hi` = 0.
- R2: In every display slot `sram_addr` equals `vga_addr` and `sram_we_n` is 1.
- R3: At the end of each display slot, bits 7:0 of `sram_rdata` are captured into `vga_pixel`. The value is visible from the next cycle on.
- R4: At most one bit of `cpu_gnt` is 1 at any time. A 1 on `cpu_gnt[i]` means that processor i's access is complete. For a read, `cpu_rdata` slice i then holds the word read from `sram_addr`.
- R5: Arbitration takes place only at the end of a display slot while no grant is held. The lowest-numbered requesting processor wins, so processor 0 has the highest priority.
- R6: A grant stays with its owner, and no other processor is acknowledged, until the owner lowers its request. The acknowledge falls one cycle after the request drops.
- R7: Each grant produces exactly one access, in the processor slot that follows the arbitration. A write drives `sram_we_n` low for exactly that one cycle. A read never drives it low, and it is never low in a display slot.
- R8: A processor write with its width bit `cpu_wide[i]` = 1 sets `sram_be` = 2'b11 and writes all 16 bits. With `cpu_wide[i]` = 0 it sets `sram_be` = 2'b01, so only bits 7:0 change and bits 15:8 of the word keep their old value.
- R9: While `rst_n` is 0, `cpu_gnt` is all zero, `sram_we_n` is 1 and `sram_drive` is 0. At the clock edge, `vga_pixel` and every `cpu_rdata` word are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_hi | output | 1 | 1 in the display slot, 0 in the processor slot |
| vga_addr | input | AW | Scan-out read address |
| vga_pixel | output | PIXW | Registered display byte |
| cpu_req | input | NCPU | Per-processor request, held until done |
| cpu_we | input | NCPU | Per-processor write (1) or read (0) |
| cpu_wide | input | NCPU | Per-processor 16-bit (1) or low-byte (0) write |
| cpu_addr | input | NCPU*AW | Packed processor addresses, processor i at slice i |
| cpu_wdata | input | NCPU*DW | Packed processor write words |
| cpu_gnt | output | NCPU | Per-processor acknowledge, access complete |
| cpu_rdata | output | NCPU*DW | Packed registered read words |
| sram_addr | output | AW | SRAM word address |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM read data |
| sram_be | output | 2 | Byte-lane enables for a write |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_drive | output | 1 | 1 when the block drives the SRAM data bus |

## Verification
The hardest case to reach is contention. Several processors must be waiting while an owner holds its grant, and the owner's release must land at a point where the next choice depends on the slot phase. The bench raises all three requests on the same edge and holds the winner for several extra cycles, checking that no one else is acknowledged. It then releases the processors one by one, so that each new grant is chosen with the lower-priority requests still pending. A reset is also forced while a write request is pending, to confirm that nothing reaches the memory.

// File: rtl/arb_pkg.sv
// Shared types for the display/processor SRAM arbiter.
// Assumes: one memory clock, slot phase derived by toggling.
package arb_pkg;
    // Which party owns the current memory clock cycle.
    typedef enum logic {
        SLOT_VGA = 1'b0,
        SLOT_CPU = 1'b1
    } slot_e;
endpackage

// File: rtl/arb_slot_phase.sv
// Slot sequencer: alternates display and processor slots on every memory
// clock. Assumes the memory clock runs at twice the pixel rate; reset parks
// the sequencer in the display slot.
module arb_slot_phase
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);
    // Toggle the slot owner every cycle; reset returns to the display slot.
    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SLOT_VGA;
        else        slot <= (slot == SLOT_VGA) ? SLOT_CPU : SLOT_VGA;
    end

    // R1: consecutive cycles out of reset never share an owner.
    a_r1_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_VGA) |=> (slot == SLOT_CPU));
endmodule

// File: rtl/arb_cpu_grant.sv
// Processor grant keeper: picks the lowest-numbered requester at the end of
// a display slot when idle, lets it make one access in the next processor
// slot, then holds the acknowledge until the owner drops its request.
// Assumes requesters keep their request stable until acknowledged.
module arb_cpu_grant
    import arb_pkg::*;
#(
    parameter int NCPU = 3,
    localparam int IW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  slot_e           slot,
    input  logic [NCPU-1:0] req,
    output logic            acc,
    output logic [IW-1:0]   owner,
    output logic [NCPU-1:0] gnt
);
    logic          busy;
    logic          done;
    logic [IW-1:0] pick;

    // Fixed priority: lowest index wins.
    always_comb begin
        pick = '0;
        for (int k = NCPU - 1; k >= 0; k--) begin
            if (req[k]) pick = IW'(k);
        end
    end

    // Grant state: claim, single access, hold, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            owner <= '0;
        end else if (busy) begin
            if (done && !req[owner]) busy <= 1'b0;
            else if (slot == SLOT_CPU) done <= 1'b1;
        end else if (slot == SLOT_VGA && |req) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            owner <= pick;
        end
    end

    assign acc = busy && !done;

    // Acknowledge lines, one per processor.
    for (genvar i = 0; i < NCPU; i++) begin : g_gnt
        assign gnt[i] = busy && done && (owner == IW'(i));

        // R5: a requester at arbitration time never loses to a higher index.
        a_r5_priority: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && slot == SLOT_VGA && req[i]) |=> (owner <= IW'(i)));
    end

    // R4: at most one acknowledge at a time.
    a_r4_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R6: the owner keeps its grant until it has been served and released.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (!done || req[owner])) |=> (busy && $stable(owner)));
endmodule

// File: rtl/arb_sram_path.sv
// SRAM datapath: steers the address and write controls from the display
// reader or the granted processor by slot, and captures read data into the
// display register or the owner's read register. Assumes the SRAM returns
// read data within the same memory cycle.
module arb_sram_path
    import arb_pkg::*;
#(
    parameter int NCPU = 3,
    parameter int AW   = 18,
    parameter int DW   = 16,
    parameter int PIXW = 8,
    localparam int IW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  slot_e              slot,
    input  logic               acc,
    input  logic [IW-1:0]      owner,
    input  logic [AW-1:0]      vga_addr,
    input  logic [NCPU-1:0]    cpu_we,
    input  logic [NCPU-1:0]    cpu_wide,
    input  logic [NCPU*AW-1:0] cpu_addr,
    input  logic [NCPU*DW-1:0] cpu_wdata,
    input  logic [DW-1:0]      sram_rdata,
    output logic [AW-1:0]      sram_addr,
    output logic [DW-1:0]      sram_wdata,
    output logic [1:0]         sram_be,
    output logic               sram_we_n,
    output logic               sram_drive,
    output logic [PIXW-1:0]    vga_pixel,
    output logic [NCPU*DW-1:0] cpu_rdata
);
    logic [AW-1:0] addr_a  [NCPU];
    logic [DW-1:0] wdata_a [NCPU];
    logic [DW-1:0] rd_q    [NCPU];
    logic          cpu_turn;
    logic          wr;

    // Unpack the processor buses and register one read word per processor.
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        assign addr_a[i]  = cpu_addr[i*AW +: AW];
        assign wdata_a[i] = cpu_wdata[i*DW +: DW];
        assign cpu_rdata[i*DW +: DW] = rd_q[i];

        // Capture a read for processor i in its access slot.
        always_ff @(posedge clk) begin
            if (!rst_n) rd_q[i] <= '0;
            else if (cpu_turn && owner == IW'(i) && !cpu_we[i]) rd_q[i] <= sram_rdata;
        end
    end

    assign cpu_turn = (slot == SLOT_CPU) && acc;

    // Steer the SRAM address, write strobe and byte lanes by slot.
    always_comb begin
        wr         = cpu_turn && cpu_we[owner];
        sram_addr  = cpu_turn ? addr_a[owner] : vga_addr;
        sram_wdata = wdata_a[owner];
        sram_be    = (wr && !cpu_wide[owner]) ? 2'b01 : 2'b11;
        sram_we_n  = !(rst_n && wr);
        sram_drive = rst_n && wr;
    end

    // Capture the display byte at the end of every display slot.
    always_ff @(posedge clk) begin
        if (!rst_n) vga_pixel <= '0;
        else if (slot == SLOT_VGA) vga_pixel <= sram_rdata[PIXW-1:0];
    end

    // R7: a write strobe only appears in a processor slot with a pending access.
    a_r7_we_in_cpu_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (slot == SLOT_CPU && acc));

    // R9: reset keeps the bus undriven and the strobe idle.
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (sram_we_n && !sram_drive));
endmodule

// File: rtl/vga_cpu_sram_arb.sv
// Top: one SRAM port time-shared between a display reader (every other
// memory cycle) and NCPU processors sharing the remaining cycles by fixed
// priority with a request/acknowledge handshake. Assumes memory clock = 2x
// pixel clock and a single-cycle asynchronous-read SRAM.
module vga_cpu_sram_arb
    import arb_pkg::*;
#(
    parameter int NCPU = 3,
    parameter int AW   = 18,
    parameter int DW   = 16,
    parameter int PIXW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               pix_hi,
    input  logic [AW-1:0]      vga_addr,
    output logic [PIXW-1:0]    vga_pixel,
    input  logic [NCPU-1:0]    cpu_req,
    input  logic [NCPU-1:0]    cpu_we,
    input  logic [NCPU-1:0]    cpu_wide,
    input  logic [NCPU*AW-1:0] cpu_addr,
    input  logic [NCPU*DW-1:0] cpu_wdata,
    output logic [NCPU-1:0]    cpu_gnt,
    output logic [NCPU*DW-1:0] cpu_rdata,
    output logic [AW-1:0]      sram_addr,
    output logic [DW-1:0]      sram_wdata,
    input  logic [DW-1:0]      sram_rdata,
    output logic [1:0]         sram_be,
    output logic               sram_we_n,
    output logic               sram_drive
);
    localparam int IW = (NCPU > 1) ? $clog2(NCPU) : 1;

    slot_e         slot;
    logic          acc;
    logic [IW-1:0] owner;

    arb_slot_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    arb_cpu_grant #(.NCPU(NCPU)) u_grant (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot),
        .req   (cpu_req),
        .acc   (acc),
        .owner (owner),
        .gnt   (cpu_gnt)
    );

    arb_sram_path #(.NCPU(NCPU), .AW(AW), .DW(DW), .PIXW(PIXW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .acc        (acc),
        .owner      (owner),
        .vga_addr   (vga_addr),
        .cpu_we     (cpu_we),
        .cpu_wide   (cpu_wide),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .sram_rdata (sram_rdata),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_be    (sram_be),
        .sram_we_n  (sram_we_n),
        .sram_drive (sram_drive),
        .vga_pixel  (vga_pixel),
        .cpu_rdata  (cpu_rdata)
    );

    assign pix_hi = (slot == SLOT_VGA);

    // R2: the display slot always presents the scan-out address, read-only.
    a_r2_display_slot: assert property (@(posedge clk) disable iff (!rst_n)
        pix_hi |-> (sram_addr == vga_addr && sram_we_n));
endmodule

// File: tb/sim_vga_cpu_sram_arb.sv
module sim_vga_cpu_sram_arb;
    localparam int NCPU = 3;
    localparam int AW   = 18;
    localparam int DW   = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pix_hi;
    logic [AW-1:0]      vga_addr = '0;
    logic [7:0]         vga_pixel;
    logic [NCPU-1:0]    cpu_req = '0;
    logic [NCPU-1:0]    cpu_we = '0;
    logic [NCPU-1:0]    cpu_wide = '0;
    logic [NCPU*AW-1:0] cpu_addr = '0;
    logic [NCPU*DW-1:0] cpu_wdata = '0;
    logic [NCPU-1:0]    cpu_gnt;
    logic [NCPU*DW-1:0] cpu_rdata;
    logic [AW-1:0]      sram_addr;
    logic [DW-1:0]      sram_wdata;
    logic [DW-1:0]      sram_rdata;
    logic [1:0]         sram_be;
    logic               sram_we_n;
    logic               sram_drive;

    int n_chk = 0;
    int n_bad = 0;
    int we_low = 0;
    int slot_bad = 0;

    always #10 clk = ~clk;

    vga_cpu_sram_arb u0 (.*);

    // SRAM model: untouched words read a seed pattern; writes honour lanes.
    logic [15:0] mem   [256];
    logic        wrote [256];
    function automatic logic [15:0] seed(input logic [7:0] a);
        return {a ^ 8'h5A, a};
    endfunction
    function automatic logic [15:0] peek(input logic [7:0] a);
        return (wrote[a] === 1'b1) ? mem[a] : seed(a);
    endfunction
    assign sram_rdata = peek(sram_addr[7:0]);

    always @(posedge clk) begin
        if (!sram_we_n && sram_drive) begin
            logic [15:0] cur;
            cur = peek(sram_addr[7:0]);
            if (sram_be[0]) cur[7:0]  = sram_wdata[7:0];
            if (sram_be[1]) cur[15:8] = sram_wdata[15:8];
            mem[sram_addr[7:0]]   <= cur;
            wrote[sram_addr[7:0]] <= 1'b1;
        end
    end

    // Port monitors: strobe count and display-slot discipline (R2, R7).
    always @(negedge clk) begin
        if (!sram_we_n) we_low++;
        if (rst_n && pix_hi && (sram_addr != vga_addr || !sram_we_n)) slot_bad++;
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wait_gnt(output logic [NCPU-1:0] g);
        int n = 0;
        do begin @(negedge clk); n++; end while (cpu_gnt == '0 && n < 60);
        g = cpu_gnt;
    endtask

    // One complete handshake for one processor.
    task automatic txn(input int id, input logic we, input logic wide, input logic [7:0] a,
                       input logic [15:0] wd, output logic [15:0] rd, output int strobes);
        logic [NCPU-1:0] g;
        int w0;
        w0 = we_low;
        cpu_we[id]               <= we;
        cpu_wide[id]             <= wide;
        cpu_addr[id*AW +: AW]    <= AW'(a);
        cpu_wdata[id*DW +: DW]   <= wd;
        cpu_req[id]              <= 1'b1;
        wait_gnt(g);
        check("R4 single acknowledge", 32'(g), 32'(1 << id));
        rd = cpu_rdata[id*DW +: DW];
        cpu_req[id] <= 1'b0;
        @(negedge clk);
        check("R6 acknowledge falls after release", 32'(cpu_gnt), 32'd0);
        strobes = we_low - w0;
    endtask

    // id[43:42] we[41] wide[40] addr[39:32] wdata[31:16] expected read[15:0]
    localparam logic [43:0] VEC [8] = '{
        {2'd0, 1'b1, 1'b1, 8'h10, 16'hABCD, 16'h0000},
        {2'd1, 1'b0, 1'b0, 8'h10, 16'h0000, 16'hABCD},
        {2'd2, 1'b1, 1'b0, 8'h10, 16'h0012, 16'h0000},
        {2'd0, 1'b0, 1'b0, 8'h10, 16'h0000, 16'hAB12},
        {2'd1, 1'b1, 1'b1, 8'h20, 16'h5A5A, 16'h0000},
        {2'd2, 1'b0, 1'b0, 8'h20, 16'h0000, 16'h5A5A},
        {2'd2, 1'b1, 1'b0, 8'h21, 16'h77FF, 16'h0000},
        {2'd0, 1'b0, 1'b0, 8'h21, 16'h0000, 16'h7BFF}
    };

    task automatic vga_probe(input logic [7:0] a, input logic [7:0] exp);
        vga_addr <= AW'(a);
        do @(negedge clk); while (pix_hi);
        check("R3 display byte", 32'(vga_pixel), 32'(exp));
    endtask

    initial begin
        logic [15:0] rd;
        logic [NCPU-1:0] g;
        int st;
        int hold_bad;
        int alt_bad;

        // R9 reset state.
        repeat (3) @(negedge clk);
        check("R9 no grant in reset", 32'(cpu_gnt), 32'd0);
        check("R9 strobe idle in reset", 32'(sram_we_n), 32'd1);
        check("R9 bus undriven in reset", 32'(sram_drive), 32'd0);
        check("R9 pixel cleared", 32'(vga_pixel), 32'd0);
        check("R1 display slot in reset", 32'(pix_hi), 32'd1);
        rst_n <= 1'b1;

        // R1 alternation from the first cycle after reset.
        alt_bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (pix_hi !== logic'(k % 2)) alt_bad++;
        end
        check("R1 slot alternation", 32'(alt_bad), 32'd0);

        // Table walk: writes, byte writes, reads by each processor.
        for (int k = 0; k < 8; k++) begin
            txn(int'(VEC[k][43:42]), VEC[k][41], VEC[k][40], VEC[k][39:32], VEC[k][31:16], rd, st);
            if (VEC[k][41]) begin
                check("R7 one strobe per write", 32'(st), 32'd1);
            end else begin
                check("R7 no strobe on read", 32'(st), 32'd0);
                check("R4 R8 read word", 32'(rd), 32'(VEC[k][15:0]));
            end
        end

        // R3 display path, including a word a processor byte-wrote.
        vga_probe(8'h33, 8'h33);
        vga_probe(8'h10, 8'h12);

        // R5 R6 contention: all three request on the same edge.
        cpu_we <= '0;
        for (int i = 0; i < NCPU; i++) cpu_addr[i*AW +: AW] <= AW'(8'h40 + i);
        cpu_req <= 3'b111;
        wait_gnt(g);
        check("R5 processor 0 wins", 32'(g), 32'b001);
        check("R4 read for processor 0", 32'(cpu_rdata[0 +: DW]), 32'h1A40);
        hold_bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cpu_gnt !== 3'b001) hold_bad++;
        end
        check("R6 grant held by owner", 32'(hold_bad), 32'd0);
        cpu_req[0] <= 1'b0;
        @(negedge clk);
        wait_gnt(g);
        check("R5 processor 1 next", 32'(g), 32'b010);
        check("R4 read for processor 1", 32'(cpu_rdata[DW +: DW]), 32'h1B41);
        cpu_req[1] <= 1'b0;
        @(negedge clk);
        wait_gnt(g);
        check("R5 processor 2 last", 32'(g), 32'b100);
        check("R4 read for processor 2", 32'(cpu_rdata[2*DW +: DW]), 32'h1842);
        cpu_req[2] <= 1'b0;
        @(negedge clk);
        check("R6 all released", 32'(cpu_gnt), 32'd0);

        // R9 reset during a pending write: nothing reaches memory.
        st = we_low;
        cpu_we[1] <= 1'b1;
        cpu_wide[1] <= 1'b1;
        cpu_addr[DW +: AW] <= AW'(8'h50);
        cpu_wdata[DW +: DW] <= 16'hDEAD;
        cpu_req[1] <= 1'b1;
        rst_n <= 1'b0;
        repeat (3) @(negedge clk);
        check("R9 no grant while reset pending", 32'(cpu_gnt), 32'd0);
        check("R9 no strobe while reset pending", 32'(we_low - st), 32'd0);
        check("R9 read words cleared", 32'(cpu_rdata == '0), 32'd1);
        cpu_req <= '0;
        rst_n <= 1'b1;
        @(negedge clk);
        txn(0, 1'b0, 1'b0, 8'h50, 16'h0, rd, st);
        check("R9 word untouched by reset", 32'(rd), 32'h0A50);

        check("R2 R7 display slot discipline", 32'(slot_bad), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still summarises.
    initial begin
        #(20ns * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule